// File: doc/BRIEF.md
# Interrupt Acknowledge and Vector Unit

This block decides when an 8-bit microcontroller core takes an interrupt, and which one. Six request sources feed it: two external request lines, overflow flags from two basic timers, a serial port with separate receive and transmit flags, and a third timer with an overflow flag and an external-capture flag. The block acts only at an instruction boundary, which the core marks with a strobe. At that point it gates every source with a global enable and a per-source enable. If nothing is already being serviced, it takes the highest-ranked pending source.

On an acknowledge, the block registers the selected service address and raises a one-cycle request for the core to push the program counter. The status word is not saved. In the same cycle the block issues hardware clear pulses, but only to flags that are cleared automatically. An in-service state then blocks further acknowledges. Only the return-from-interrupt strobe ends that state; a plain subroutine return leaves it unchanged.

Top module: `irq_ack_unit`

## Requirements
- R1: After synchronous reset, `vec_addr` is 0x0000, and `push_pc`, `irq_active` and every bit of `flag_clr` are 0.
- R2: The block acknowledges when, in one cycle, `insn_done` is 1, `irq_active` is 0, `reti_stb` is 0, `glb_en` is 1 and at least one enabled source is pending. In the following cycle `push_pc` is 1 and `irq_active` is 1. No acknowledge happens without `insn_done`.
- R3: Sources are indexed 0 ext0, 1 timer0, 2 ext1, 3 timer1, 4 serial, 5 timer2. The lowest pending index wins. `vec_addr` becomes 0x0003 + 8*index and holds until the next acknowledge.
- R4: `flag_clr` bit 0 (ext0) and bit 2 (ext1) pulse on acknowledge of that external source only when its `ext_edge_mode` bit is 1. Bit 0 of `ext_edge_mode` belongs to ext0 and bit 1 to ext1. In level mode (bit 0) the flag is not cleared.
- R5: Acknowledging timer0 always pulses `flag_clr` bit 1, and acknowledging timer1 always pulses `flag_clr` bit 3.
- R6: Acknowledging the serial or timer2 source pulses no bit of `flag_clr`.
- R7: The serial source is pending when either its receive or its transmit flag is 1. Timer2 is pending when either of its two flags is 1.
- R8: A source whose `src_en` bit (same indexing as R3) is 0, or any source while `glb_en` is 0, neither vectors nor has its flag cleared.
- R9: While `irq_active` is 1, no acknowledge occurs. `ret_stb` leaves `irq_active` unchanged.
- R10: `reti_stb` clears `irq_active` in the next cycle, after which acknowledges are accepted again.
- R11: `push_pc` lasts exactly one cycle. `flag_clr` pulses only together with `push_pc`, with at most one bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext0_flag | input | 1 | External request 0 flag |
| tmr0_ovf | input | 1 | Timer 0 overflow flag |
| ext1_flag | input | 1 | External request 1 flag |
| tmr1_ovf | input | 1 | Timer 1 overflow flag |
| ser_rx_flag | input | 1 | Serial receive flag |
| ser_tx_flag | input | 1 | Serial transmit flag |
| tmr2_ovf | input | 1 | Timer 2 overflow flag |
| tmr2_cap_flag | input | 1 | Timer 2 external capture/reload flag |
| glb_en | input | 1 | Global interrupt enable |
| src_en | input | 6 | Per-source enables, indexed as in R3 |
| ext_edge_mode | input | 2 | 1 = transition-activated external source (bit 0 ext0, bit 1 ext1) |
| insn_done | input | 1 | Instruction boundary strobe |
| reti_stb | input | 1 | Return-from-interrupt strobe |
| ret_stb | input | 1 | Plain return strobe |
| vec_addr | output | 16 | Registered service address |
| push_pc | output | 1 | One-cycle request to push the program counter |
| irq_active | output | 1 | Interrupt in service |
| flag_clr | output | 4 | Hardware clear pulses: bit0 ext0, bit1 tmr0, bit2 ext1, bit3 tmr1 |

## Verification
The bound checker evaluates the cycle-local rules on every clock edge. These are the single-cycle width of `push_pc` and the rule that clear pulses occur only together with it, one at a time. They also include the blocking of acknowledges while in service, the retention of the in-service state across a plain return, and its release by return-from-interrupt. Some outcomes depend on the actual input values: which source wins a collision, the exact service address, and whether an external flag is cleared in edge or level mode. Only the bench's reference model can confirm these, and it does so across random and directed scenarios.

// File: rtl/irq_ack_pkg.sv
package irq_ack_pkg;
  localparam int NSRC  = 6;
  localparam int IDX_W = $clog2(NSRC);
  localparam int NCLR  = 4;

  typedef enum logic [IDX_W-1:0] {
    SRC_EXT0 = 3'd0,
    SRC_TMR0 = 3'd1,
    SRC_EXT1 = 3'd2,
    SRC_TMR1 = 3'd3,
    SRC_SER  = 3'd4,
    SRC_TMR2 = 3'd5
  } src_e;
endpackage

// File: rtl/irq_req_gate.sv
module irq_req_gate #(
  parameter int N = 6
) (
  input  logic [N-1:0] raw_req,
  input  logic [N-1:0] src_en,
  input  logic         glb_en,
  output logic [N-1:0] pend
);
  for (genvar i = 0; i < N; i++) begin : g_gate
    assign pend[i] = raw_req[i] & src_en[i] & glb_en;
  end
endmodule

// File: rtl/irq_prio_sel.sv
module irq_prio_sel #(
  parameter int N     = 6,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     req,
  output logic [N-1:0]     grant,
  output logic [IDX_W-1:0] idx,
  output logic             any
);
  logic [N:0] lower_busy;
  assign lower_busy[0] = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_chain
    assign grant[i]        = req[i] & ~lower_busy[i];
    assign lower_busy[i+1] = lower_busy[i] | req[i];
  end

  assign any = lower_busy[N];

  always_comb begin
    idx = '0;
    for (int k = 0; k < N; k++) begin
      if (grant[k]) idx = IDX_W'(k);
    end
  end
endmodule

// File: rtl/irq_clr_ctrl.sv
module irq_clr_ctrl
  import irq_ack_pkg::*;
(
  input  logic            take,
  input  logic [NSRC-1:0] grant,
  input  logic [1:0]      edge_mode,
  output logic [NCLR-1:0] clr
);
  always_comb begin
    clr    = '0;
    clr[0] = take & grant[SRC_EXT0] & edge_mode[0];
    clr[1] = take & grant[SRC_TMR0];
    clr[2] = take & grant[SRC_EXT1] & edge_mode[1];
    clr[3] = take & grant[SRC_TMR1];
  end
endmodule

// File: rtl/irq_vec_gen.sv
module irq_vec_gen #(
  parameter int ADDR_W = 16,
  parameter int IDX_W  = 3,
  parameter int BASE   = 3,
  parameter int STRIDE = 8
) (
  input  logic [IDX_W-1:0]  idx,
  output logic [ADDR_W-1:0] addr
);
  localparam logic [ADDR_W-1:0] BASE_V   = ADDR_W'(BASE);
  localparam logic [ADDR_W-1:0] STRIDE_V = ADDR_W'(STRIDE);

  assign addr = BASE_V + ADDR_W'(idx) * STRIDE_V;
endmodule

// File: rtl/irq_ack_unit.sv
module irq_ack_unit
  import irq_ack_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int VEC_BASE   = 3,
  parameter int VEC_STRIDE = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ext0_flag,
  input  logic              tmr0_ovf,
  input  logic              ext1_flag,
  input  logic              tmr1_ovf,
  input  logic              ser_rx_flag,
  input  logic              ser_tx_flag,
  input  logic              tmr2_ovf,
  input  logic              tmr2_cap_flag,
  input  logic              glb_en,
  input  logic [NSRC-1:0]   src_en,
  input  logic [1:0]        ext_edge_mode,
  input  logic              insn_done,
  input  logic              reti_stb,
  input  logic              ret_stb,
  output logic [ADDR_W-1:0] vec_addr,
  output logic              push_pc,
  output logic              irq_active,
  output logic [NCLR-1:0]   flag_clr
);
  logic [NSRC-1:0]   raw_req;
  logic [NSRC-1:0]   pend;
  logic [NSRC-1:0]   grant;
  logic [IDX_W-1:0]  win_idx;
  logic              any_pend;
  logic              take;
  logic [NCLR-1:0]   clr_nxt;
  logic [ADDR_W-1:0] vec_nxt;

  always_comb begin
    raw_req           = '0;
    raw_req[SRC_EXT0] = ext0_flag;
    raw_req[SRC_TMR0] = tmr0_ovf;
    raw_req[SRC_EXT1] = ext1_flag;
    raw_req[SRC_TMR1] = tmr1_ovf;
    raw_req[SRC_SER]  = ser_rx_flag | ser_tx_flag;
    raw_req[SRC_TMR2] = tmr2_ovf | tmr2_cap_flag;
  end

  irq_req_gate #(.N(NSRC)) u_gate (
    .raw_req (raw_req),
    .src_en  (src_en),
    .glb_en  (glb_en),
    .pend    (pend)
  );

  irq_prio_sel #(.N(NSRC), .IDX_W(IDX_W)) u_sel (
    .req   (pend),
    .grant (grant),
    .idx   (win_idx),
    .any   (any_pend)
  );

  // Acknowledge only at an instruction boundary, out of service, no RETI pending.
  assign take = insn_done & ~irq_active & ~reti_stb & any_pend;

  irq_clr_ctrl u_clr (
    .take      (take),
    .grant     (grant),
    .edge_mode (ext_edge_mode),
    .clr       (clr_nxt)
  );

  irq_vec_gen #(
    .ADDR_W (ADDR_W),
    .IDX_W  (IDX_W),
    .BASE   (VEC_BASE),
    .STRIDE (VEC_STRIDE)
  ) u_vec (
    .idx  (win_idx),
    .addr (vec_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      vec_addr   <= '0;
      push_pc    <= 1'b0;
      irq_active <= 1'b0;
      flag_clr   <= '0;
    end else begin
      push_pc  <= take;
      flag_clr <= clr_nxt;
      if (take) vec_addr <= vec_nxt;
      if (reti_stb)  irq_active <= 1'b0;
      else if (take) irq_active <= 1'b1;
    end
  end
endmodule

// File: rtl/irq_ack_unit_chk.sv
module irq_ack_unit_chk
  import irq_ack_pkg::*;
(
  input logic            clk,
  input logic            rst,
  input logic            glb_en,
  input logic            insn_done,
  input logic            reti_stb,
  input logic            ret_stb,
  input logic            push_pc,
  input logic            irq_active,
  input logic [NCLR-1:0] flag_clr
);
  AST_PUSH_SINGLE: assert property (@(posedge clk) disable iff (rst)
    push_pc |=> !push_pc); // R11
  AST_CLR_WITH_PUSH: assert property (@(posedge clk) disable iff (rst)
    (|flag_clr) |-> push_pc); // R11
  AST_CLR_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(flag_clr)); // R11
  AST_PUSH_AT_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
    !insn_done |=> !push_pc); // R2
  AST_PUSH_MARKS_ACTIVE: assert property (@(posedge clk) disable iff (rst)
    push_pc |-> irq_active); // R2
  AST_NO_NEST: assert property (@(posedge clk) disable iff (rst)
    irq_active |=> !push_pc); // R9
  AST_RET_KEEPS_ACTIVE: assert property (@(posedge clk) disable iff (rst)
    (irq_active && ret_stb && !reti_stb) |=> irq_active); // R9
  AST_RETI_RELEASES: assert property (@(posedge clk) disable iff (rst)
    reti_stb |=> !irq_active); // R10
  AST_GLOBAL_GATE: assert property (@(posedge clk) disable iff (rst)
    !glb_en |=> !push_pc); // R8
endmodule

bind irq_ack_unit irq_ack_unit_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .glb_en     (glb_en),
  .insn_done  (insn_done),
  .reti_stb   (reti_stb),
  .ret_stb    (ret_stb),
  .push_pc    (push_pc),
  .irq_active (irq_active),
  .flag_clr   (flag_clr)
);

// File: tb/irq_ack_unit_tb_top.sv
module irq_ack_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        ext0_flag, tmr0_ovf, ext1_flag, tmr1_ovf;
  logic        ser_rx_flag, ser_tx_flag, tmr2_ovf, tmr2_cap_flag;
  logic        glb_en;
  logic [5:0]  src_en;
  logic [1:0]  ext_edge_mode;
  logic        insn_done, reti_stb, ret_stb;
  logic [15:0] vec_addr;
  logic        push_pc, irq_active;
  logic [3:0]  flag_clr;

  int total = 0;
  int bad   = 0;
  bit m_active;
  logic [15:0] m_vec;

  always #5 clk = ~clk;

  irq_ack_unit dut_i (
    .clk(clk), .rst(rst),
    .ext0_flag(ext0_flag), .tmr0_ovf(tmr0_ovf), .ext1_flag(ext1_flag),
    .tmr1_ovf(tmr1_ovf), .ser_rx_flag(ser_rx_flag), .ser_tx_flag(ser_tx_flag),
    .tmr2_ovf(tmr2_ovf), .tmr2_cap_flag(tmr2_cap_flag),
    .glb_en(glb_en), .src_en(src_en), .ext_edge_mode(ext_edge_mode),
    .insn_done(insn_done), .reti_stb(reti_stb), .ret_stb(ret_stb),
    .vec_addr(vec_addr), .push_pc(push_pc), .irq_active(irq_active),
    .flag_clr(flag_clr)
  );

  function automatic logic [5:0] ref_pend();
    logic [5:0] r;
    r = {tmr2_ovf | tmr2_cap_flag, ser_rx_flag | ser_tx_flag,
         tmr1_ovf, ext1_flag, tmr0_ovf, ext0_flag};
    return glb_en ? (r & src_en) : 6'b0;
  endfunction

  function automatic int ref_idx(logic [5:0] p);
    for (int i = 5; i >= 0; i--) if (p[i]) ref_idx = i;
    if (p == 0) ref_idx = -1;
  endfunction

  function automatic logic [3:0] ref_clr(int idx);
    logic [3:0] c;
    c = 4'b0;
    if (idx == 0 && ext_edge_mode[0]) c[0] = 1'b1;
    if (idx == 1) c[1] = 1'b1;
    if (idx == 2 && ext_edge_mode[1]) c[2] = 1'b1;
    if (idx == 3) c[3] = 1'b1;
    return c;
  endfunction

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clear_inputs();
    {ext0_flag, tmr0_ovf, ext1_flag, tmr1_ovf} = 4'b0;
    {ser_rx_flag, ser_tx_flag, tmr2_ovf, tmr2_cap_flag} = 4'b0;
    glb_en = 1'b1; src_en = 6'h3F; ext_edge_mode = 2'b11;
    insn_done = 1'b0; reti_stb = 1'b0; ret_stb = 1'b0;
  endtask

  // Inputs are set at the negedge before the call; the call models one edge and compares.
  task automatic cyc(string tag);
    bit take;
    int idx;
    logic [3:0] eclr;
    idx  = ref_idx(ref_pend());
    take = insn_done && !m_active && !reti_stb && (idx >= 0);
    eclr = take ? ref_clr(idx) : 4'b0;
    if (take) m_vec = 16'h0003 + 16'(idx) * 16'd8;
    if (reti_stb) m_active = 1'b0;
    else if (take) m_active = 1'b1;
    @(posedge clk); @(negedge clk);
    check({tag, " R2 push"}, 16'(push_pc), 16'(take));
    check({tag, " R3 vec"}, vec_addr, m_vec);
    check({tag, " R4/R5/R6 clr"}, 16'(flag_clr), 16'(eclr));
    check({tag, " R9/R10 active"}, 16'(irq_active), 16'(m_active));
  endtask

  task automatic idle(string tag);
    insn_done = 1'b0; reti_stb = 1'b0; ret_stb = 1'b0;
    cyc(tag);
  endtask

  task automatic release_irq();
    clear_inputs();
    reti_stb = 1'b1; cyc("R10 reti");
    reti_stb = 1'b0;
  endtask

  initial begin
    #2_000_000;
    bad++; total++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd5150));
    clear_inputs();
    rst = 1'b1;
    m_active = 1'b0; m_vec = 16'h0000;
    @(posedge clk); @(posedge clk); @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 vec", vec_addr, 16'h0000);
    check("R1 push", 16'(push_pc), 16'd0);
    check("R1 active", 16'(irq_active), 16'd0);
    check("R1 clr", 16'(flag_clr), 16'd0);

    // R2: pending without boundary strobe is not taken
    ext0_flag = 1'b1; cyc("R2 no boundary");
    // R3/R4: all pending, ext0 wins, edge mode clears it
    {ext0_flag, tmr0_ovf, ext1_flag, tmr1_ovf, ser_rx_flag, tmr2_ovf} = 6'h3F;
    insn_done = 1'b1; cyc("R3 all pending");
    check("R3 vec ext0", vec_addr, 16'h0003);
    check("R4 edge clr ext0", 16'(flag_clr), 16'h1);
    check("R11 push width", 16'(push_pc), 16'd1);
    idle("R11 after");
    check("R11 push drop", 16'(push_pc), 16'd0);
    // R9: ret does not end service; no nesting
    insn_done = 1'b1; ret_stb = 1'b1; cyc("R9 ret");
    check("R9 still active", 16'(irq_active), 16'd1);
    release_irq();

    // R4 level mode: ext1 taken, not cleared
    ext1_flag = 1'b1; ext_edge_mode = 2'b00; insn_done = 1'b1; cyc("R4 level");
    check("R4 level no clr", 16'(flag_clr), 16'h0);
    check("R3 vec ext1", vec_addr, 16'h0013);
    release_irq();

    // R5 timer1 cleared always
    tmr1_ovf = 1'b1; ext_edge_mode = 2'b00; insn_done = 1'b1; cyc("R5 tmr1");
    check("R5 tmr1 clr", 16'(flag_clr), 16'h8);
    check("R3 vec tmr1", vec_addr, 16'h001B);
    release_irq();

    // R6/R7 serial tx only
    ser_tx_flag = 1'b1; insn_done = 1'b1; cyc("R7 ser tx");
    check("R7 vec serial", vec_addr, 16'h0023);
    check("R6 serial no clr", 16'(flag_clr), 16'h0);
    release_irq();

    // R7 timer2 capture flag only
    tmr2_cap_flag = 1'b1; insn_done = 1'b1; cyc("R7 tmr2 cap");
    check("R7 vec tmr2", vec_addr, 16'h002B);
    check("R6 tmr2 no clr", 16'(flag_clr), 16'h0);
    release_irq();

    // R8 ext0 disabled, tmr0 wins
    ext0_flag = 1'b1; tmr0_ovf = 1'b1; src_en = 6'h3E; insn_done = 1'b1; cyc("R8 src off");
    check("R8 vec tmr0", vec_addr, 16'h000B);
    check("R8 no ext0 clr", 16'(flag_clr), 16'h2);
    release_irq();
    // R8 global off
    ext0_flag = 1'b1; glb_en = 1'b0; insn_done = 1'b1; cyc("R8 glb off");
    check("R8 no push", 16'(push_pc), 16'd0);
    check("R8 no clr", 16'(flag_clr), 16'h0);
    clear_inputs();

    // Random traffic against the model
    for (int n = 0; n < 3000; n++) begin
      {ext0_flag, tmr0_ovf, ext1_flag, tmr1_ovf} = 4'($urandom);
      {ser_rx_flag, ser_tx_flag, tmr2_ovf, tmr2_cap_flag} = 4'($urandom) & 4'($urandom);
      glb_en        = ($urandom % 8) != 0;
      src_en        = 6'($urandom);
      ext_edge_mode = 2'($urandom);
      insn_done     = ($urandom % 3) == 0;
      reti_stb      = ($urandom % 6) == 0;
      ret_stb       = ($urandom % 5) == 0;
      cyc("rand");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule